// File: doc/BRIEF.md
# Power-Management Event Timer

This block is a free-running power-management timer joined to a small set of event status and enable registers, which together drive one level-sensitive system-control interrupt. The timer advances once for each pulse on a tick-enable input. That input is supplied at 3,579,545 Hz by clock logic outside the block. Each time the top bit of the count changes, the block latches a timer-overflow event. Other event sources raise status bits through single-cycle pulse inputs: a global event, a real-time-clock alarm, a resume indication and a power-button press.

Software reaches the registers through a 16-bit port inside a relocatable 64-byte I/O window. The window base comes from a configuration word whose six low bits are ignored. A separate configuration enable bit turns decoding on. Status bits are write-one-to-clear. A power-button press that is not enabled does not set status; the block instead requests a shutdown.

Top module: `pm_evt_timer`

## Requirements
- R1: After reset, the status, enable and control registers and the timer count are all zero, and `sci_o` and `shutdown_req_o` are low.
- R2: The timer count rises by exactly one on each clock where `tick_i` is high and holds otherwise. A read at window offset 8 returns the count zero-extended to 32 bits.
- R3: Status bit 0 (timer overflow) is set on every tick that changes bit TMR_W-1 of the count. This covers both directions, so it happens on every multiple of 2^(TMR_W-1) counts (0x800000 at the default width of 24).
- R4: A write to the status register at offset 0 clears every bit written as 1 and leaves bits written as 0 unchanged. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R5: The enable register at offset 2 holds only bits 0, 5, 8 and 10. All other enable bits read as zero.
- R6: `sci_o` is high exactly while some status bit among bits 0, 5, 8 and 10 is set together with its enable bit. Status bit 15 never raises `sci_o`.
- R7: A pulse on `pwrbtn_i` sets status bit 8 if enable bit 8 is set. Otherwise it leaves status unchanged and drives `shutdown_req_o` high for one cycle, one clock later.
- R8: An access is accepted only when `io_dec_en_i` is high and `io_addr_i[15:6]` equals `io_base_i[15:6]`. The low six base bits are ignored. A rejected write changes no register, and a rejected read produces no `io_rvalid_o`.
- R9: The control register at offset 4 stores and returns all 16 written bits. A read of any other in-window offset returns zero.
- R10: A pulse on `gbl_evt_i` sets status bit 5, on `rtc_evt_i` sets status bit 10, and on `rsm_evt_i` sets status bit 15.
- R11: Read data appears on `io_rdata_o` with `io_rvalid_o` high in the cycle after the clock edge that samples `io_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timer tick enable, one pulse per count |
| io_base_i | input | 16 | I/O window base; low 6 bits ignored |
| io_dec_en_i | input | 1 | Window decode enable |
| io_addr_i | input | 16 | Access address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 32 | Read data |
| io_rvalid_o | output | 1 | Read data valid |
| gbl_evt_i | input | 1 | Global event pulse |
| rtc_evt_i | input | 1 | Real-time-clock alarm pulse |
| rsm_evt_i | input | 1 | Resume indication pulse |
| pwrbtn_i | input | 1 | Power-button press pulse |
| sci_o | output | 1 | Level interrupt to the system |
| shutdown_req_o | output | 1 | Shutdown request pulse |

## Verification
A wrong count or a missed overflow edge shows up in the first timer read, or the first status read after the overflow boundary. The bench therefore shrinks the count width so the boundary is reached within a few thousand ticks. A clear or enable mask that holds the wrong value appears on `sci_o` in the same cycle the register settles, so it is checked right after each write and event pulse. A decode fault appears as a register that a rejected write changed, or as a read answered when it should have been dropped. The very next readback exposes either one.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned TMR_B = 0;
  localparam int unsigned GBL_B = 5;
  localparam int unsigned PB_B  = 8;
  localparam int unsigned RTC_B = 10;
  localparam int unsigned RSM_B = 15;

  localparam logic [15:0] SCI_MASK = 16'h0521;
  localparam logic [15:0] STS_MASK = SCI_MASK | 16'h8000;

  localparam int unsigned WIN_BITS = 6;
  localparam logic [WIN_BITS-1:0] OFF_STS = 6'd0;
  localparam logic [WIN_BITS-1:0] OFF_EN  = 6'd2;
  localparam logic [WIN_BITS-1:0] OFF_CTL = 6'd4;
  localparam logic [WIN_BITS-1:0] OFF_TMR = 6'd8;

  typedef struct packed {
    logic sts;
    logic en;
    logic ctl;
    logic tmr;
  } reg_sel_t;
endpackage

// File: rtl/pm_tmr_cnt.sv
module pm_tmr_cnt #(
  parameter int unsigned TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // the next tick flips the top bit
  assign ovf_o = tick_i & (&cnt_q[TMR_W-2:0]);
  assign cnt_o = cnt_q;

  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  a_r3_ovf_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1]));
  a_r3_no_stray_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o |=> cnt_q[TMR_W-1] == $past(cnt_q[TMR_W-1]));
endmodule

// File: rtl/pm_io_dec.sv
module pm_io_dec
  import pm_evt_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic          dec_en_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic          hit_o,
  output reg_sel_t      wr_sel_o,
  output reg_sel_t      rd_sel_o
);
  localparam logic [AW-1:0] WIN_MASK = {{(AW-WIN_BITS){1'b1}}, {WIN_BITS{1'b0}}};

  logic [WIN_BITS-1:0] off;
  reg_sel_t            sel;

  assign off   = addr_i[WIN_BITS-1:0];
  assign hit_o = dec_en_i && ((addr_i & WIN_MASK) == (base_i & WIN_MASK));

  always_comb begin
    sel = '0;
    unique case (off)
      OFF_STS: sel.sts = 1'b1;
      OFF_EN:  sel.en  = 1'b1;
      OFF_CTL: sel.ctl = 1'b1;
      OFF_TMR: sel.tmr = 1'b1;
      default: sel = '0;
    endcase
  end

  assign wr_sel_o = (hit_o && wr_i) ? sel : '0;
  assign rd_sel_o = (hit_o && rd_i) ? sel : '0;

  a_r8_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_en_i |-> (wr_sel_o == '0) && (rd_sel_o == '0));
  a_r8_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_sel_o));
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  reg_sel_t    wr_sel_i,
  input  logic [15:0] wdata_i,
  input  logic        ovf_i,
  input  logic        gbl_i,
  input  logic        rtc_i,
  input  logic        rsm_i,
  input  logic        pwrbtn_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic [15:0] ctl_o,
  output logic        sci_o,
  output logic        shutdown_o
);
  logic [15:0] sts_q, en_q, ctl_q;
  logic [15:0] set_v, clr_v;
  logic        shut_q;

  always_comb begin
    set_v        = '0;
    set_v[TMR_B] = ovf_i;
    set_v[GBL_B] = gbl_i;
    set_v[PB_B]  = pwrbtn_i & en_q[PB_B];
    set_v[RTC_B] = rtc_i;
    set_v[RSM_B] = rsm_i;
    clr_v        = wr_sel_i.sts ? wdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q  <= '0;
      en_q   <= '0;
      ctl_q  <= '0;
      shut_q <= 1'b0;
    end else begin
      // set wins over a same-cycle clear
      sts_q  <= ((sts_q & ~clr_v) | set_v) & STS_MASK;
      shut_q <= pwrbtn_i & ~en_q[PB_B];
      if (wr_sel_i.en)  en_q  <= wdata_i & SCI_MASK;
      if (wr_sel_i.ctl) ctl_q <= wdata_i;
    end
  end

  assign sts_o      = sts_q;
  assign en_o       = en_q;
  assign ctl_o      = ctl_q;
  assign shutdown_o = shut_q;
  assign sci_o      = |(sts_q & en_q & SCI_MASK);

  a_r4_w1c_tmr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i.sts && wdata_i[TMR_B] && !ovf_i) |=> !sts_q[TMR_B]);
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gbl_i |=> sts_q[GBL_B]);
  a_r6_resume_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ~(16'h1 << RSM_B)) == '0) |-> !sci_o);
  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> !$rose(sts_q[PB_B]));
  a_r5_en_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~SCI_MASK) == '0);
endmodule

// File: rtl/pm_evt_timer.sv
module pm_evt_timer
  import pm_evt_pkg::*;
#(
  parameter int unsigned TMR_W = 24,
  parameter int unsigned AW    = 16,
  parameter int unsigned RD_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic [AW-1:0]   io_base_i,
  input  logic            io_dec_en_i,
  input  logic [AW-1:0]   io_addr_i,
  input  logic            io_wr_i,
  input  logic            io_rd_i,
  input  logic [15:0]     io_wdata_i,
  output logic [RD_W-1:0] io_rdata_o,
  output logic            io_rvalid_o,
  input  logic            gbl_evt_i,
  input  logic            rtc_evt_i,
  input  logic            rsm_evt_i,
  input  logic            pwrbtn_i,
  output logic            sci_o,
  output logic            shutdown_req_o
);
  logic [TMR_W-1:0] cnt;
  logic             ovf, hit;
  reg_sel_t         wr_sel, rd_sel;
  logic [15:0]      sts, en, ctl;
  logic [RD_W-1:0]  rd_mux, rdata_q;
  logic             rvalid_q;

  pm_tmr_cnt #(.TMR_W(TMR_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .cnt_o(cnt), .ovf_o(ovf)
  );

  pm_io_dec #(.AW(AW)) u_dec (
    .clk_i, .rst_ni,
    .addr_i(io_addr_i), .base_i(io_base_i), .dec_en_i(io_dec_en_i),
    .wr_i(io_wr_i), .rd_i(io_rd_i),
    .hit_o(hit), .wr_sel_o(wr_sel), .rd_sel_o(rd_sel)
  );

  pm_evt_regs u_regs (
    .clk_i, .rst_ni,
    .wr_sel_i(wr_sel), .wdata_i(io_wdata_i),
    .ovf_i(ovf), .gbl_i(gbl_evt_i), .rtc_i(rtc_evt_i), .rsm_i(rsm_evt_i),
    .pwrbtn_i(pwrbtn_i),
    .sts_o(sts), .en_o(en), .ctl_o(ctl),
    .sci_o(sci_o), .shutdown_o(shutdown_req_o)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_sel.sts) rd_mux = RD_W'(sts);
    if (rd_sel.en)  rd_mux = RD_W'(en);
    if (rd_sel.ctl) rd_mux = RD_W'(ctl);
    if (rd_sel.tmr) rd_mux = RD_W'(cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= io_rd_i && hit;
      if (io_rd_i && hit) rdata_q <= rd_mux;
    end
  end

  assign io_rdata_o  = rdata_q;
  assign io_rvalid_o = rvalid_q;

  a_r11_rvalid_follows_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rvalid_o |-> $past(io_rd_i) && $past(io_dec_en_i));
  a_r2_tmr_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_rvalid_o && $past(rd_sel.tmr)) |-> (io_rdata_o >> TMR_W) == '0);
endmodule

// File: tb/sim_pm_evt_timer.sv
module sim_pm_evt_timer;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 12;
  localparam int HALF = 1 << (TW - 1);
  localparam logic [15:0] BASE = 16'hB000;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [15:0] base = 16'hB015, addr = '0, wdata = '0;
  logic dec_en = 1, wr = 0, rd = 0;
  logic gbl = 0, rtc = 0, rsm = 0, pb = 0;
  logic [31:0] rdata;
  logic rvalid, sci, shut;

  int n_chk = 0, n_bad = 0, n_rv = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_evt_timer #(.TMR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .io_base_i(base), .io_dec_en_i(dec_en), .io_addr_i(addr),
    .io_wr_i(wr), .io_rd_i(rd), .io_wdata_i(wdata),
    .io_rdata_o(rdata), .io_rvalid_o(rvalid),
    .gbl_evt_i(gbl), .rtc_evt_i(rtc), .rsm_evt_i(rsm), .pwrbtn_i(pb),
    .sci_o(sci), .shutdown_req_o(shut)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string t);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  // monitor: pop expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      n_rv++;
      if (exp_q.size() == 0) check(rdata, 32'hDEAD, "R8 unexpected rvalid");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [31:0] exp, input string t, input bit push = 1);
    addr = a; rd = 1;
    if (push) begin exp_q.push_back(exp); tag_q.push_back(t); end
    @(negedge clk);
    rd = 0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1;
      @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1;
    @(negedge clk);
    s = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rv0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(sci, 0, "R1 sci");
    check(shut, 0, "R1 shutdown");
    io_read(BASE + 0, 0, "R1 status");
    io_read(BASE + 2, 0, "R1 enable");
    io_read(BASE + 4, 0, "R1 control");
    io_read(BASE + 8, 0, "R1 timer");
    // R2 count and hold
    ticks(5);
    io_read(BASE + 8, 5, "R2 timer after 5");
    repeat (3) @(negedge clk);
    io_read(BASE + 8, 5, "R2 timer holds");
    // R3 overflow at half range
    ticks(HALF - 1 - 5);
    io_read(BASE + 0, 0, "R3 no overflow before boundary");
    ticks(1);
    io_read(BASE + 0, 1, "R3 overflow set");
    io_read(BASE + 8, HALF, "R2 zero-extended timer");
    // R4 write-one-to-clear
    io_write(BASE + 0, 16'h0000);
    io_read(BASE + 0, 1, "R4 write zero keeps");
    io_write(BASE + 0, 16'h0001);
    io_read(BASE + 0, 0, "R4 write one clears");
    // R5 enable mask
    io_write(BASE + 2, 16'hFFFF);
    io_read(BASE + 2, 32'h0521, "R5 enable bits");
    check(sci, 0, "R6 no pending");
    // R10 / R6 global event
    pulse(gbl);
    check(sci, 1, "R6 sci on global");
    io_read(BASE + 0, 32'h0020, "R10 global bit5");
    io_write(BASE + 2, 16'h0000);
    check(sci, 0, "R6 sci gated by enable");
    io_write(BASE + 2, 16'hFFFF);
    io_write(BASE + 0, 16'h0020);
    check(sci, 0, "R6 sci after clear");
    // resume never raises sci
    pulse(rsm);
    check(sci, 0, "R6 resume quiet");
    io_read(BASE + 0, 32'h8000, "R10 resume bit15");
    pulse(rtc);
    check(sci, 1, "R6 sci on rtc");
    io_read(BASE + 0, 32'h8400, "R10 rtc bit10");
    io_write(BASE + 0, 16'hFFFF);
    io_read(BASE + 0, 0, "R4 clear all");
    // R7 power button enabled
    pulse(pb);
    check(shut, 0, "R7 no shutdown when enabled");
    check(sci, 1, "R7 sci on button");
    io_read(BASE + 0, 32'h0100, "R7 button status");
    io_write(BASE + 0, 16'h0100);
    // R7 power button disabled
    io_write(BASE + 2, 16'h0000);
    pulse(pb);
    check(shut, 1, "R7 shutdown pulse");
    @(negedge clk);
    check(shut, 0, "R7 shutdown one cycle");
    io_read(BASE + 0, 0, "R7 status untouched");
    // R4 set wins over clear
    addr = BASE + 0; wdata = 16'hFFFF; wr = 1; gbl = 1;
    @(negedge clk);
    wr = 0; gbl = 0;
    io_read(BASE + 0, 32'h0020, "R4 set beats clear");
    io_write(BASE + 0, 16'hFFFF);
    // R9 control and unmapped
    io_write(BASE + 4, 16'hA5C3);
    io_read(BASE + 4, 32'hA5C3, "R9 control readback");
    io_read(BASE + 16'h10, 0, "R9 unmapped reads zero");
    // R8 decode
    io_write(16'hC004, 16'h1111);
    io_read(BASE + 4, 32'hA5C3, "R8 foreign write ignored");
    dec_en = 0;
    io_write(BASE + 4, 16'h2222);
    rv0 = n_rv;
    io_read(BASE + 4, 0, "", 0);
    check(n_rv - rv0, 0, "R8 disabled read dropped");
    dec_en = 1;
    io_read(BASE + 4, 32'hA5C3, "R8 disabled write ignored");
    io_read(BASE + 16'h3F + 16'h0, 0, "R8 top of window hits");
    // R3 second toggle (top bit falling)
    ticks(HALF - 1);
    io_read(BASE + 0, 0, "R3 none before wrap");
    ticks(1);
    io_read(BASE + 0, 1, "R3 overflow on wrap");
    io_read(BASE + 8, 0, "R2 timer wrapped");
    // R11 latency: read result arrives one cycle after strobe
    addr = BASE + 4; rd = 1;
    exp_q.push_back(32'hA5C3); tag_q.push_back("R11 read data");
    @(negedge clk);
    rd = 0;
    check(rvalid, 1, "R11 rvalid next cycle");
    @(negedge clk);
    check(rvalid, 0, "R11 rvalid single");
    check(exp_q.size(), 0, "R11 scoreboard drained");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule